// File: doc/BRIEF.md
# Configurable Output Cell for a Sum-of-Products Logic Array

This block is one output cell of a programmable sum-of-products logic device. An upstream AND array has already evaluated the cell's product terms. Five of these terms are control terms: two asynchronous clears, two clock terms and an output enable. The remaining terms form three OR groups of equal size. A static configuration word chooses among several routings of these groups. The groups can feed a first register, a combinational pin path or a second register, which is usually buried. The second register's input or its output can be returned to the shared feedback bus.

Each register can be set to D or T behaviour, and each can have its clock term gated by a dedicated clock pin. Both registers share a synchronous preset and a test preload path. The cell drives a pin value with selectable polarity and an enable. It returns six signals to the array: three true/complement pairs.

Clocking is modelled on a single system clock. Each register takes a clock enable when its effective clock, meaning its clock term optionally ANDed with the clock pin, is high in a cycle after being low in the cycle before. The register then updates on that system edge. The active-low reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `pld_out_cell`

## Requirements
- R1: Product term positions: pt_i[0] clear1, pt_i[1] clock1, pt_i[2] clock2, pt_i[3] clear2, pt_i[4] enable. Group A is pt_i[8:5], group B is pt_i[12:9] and group C is pt_i[16:13], and each group is the OR of its bits. Configuration bit k of cfg_i is Sk, and the select code is {S1,S0}.
- R2: With S2=0 (registered), register 1 takes A|B for codes 00, 01 and 11, and takes A|B|C for code 10. Register 2 always takes C. The pin value is register 1's output.
- R3: With S2=1 (combinational), the pin value is A|B for code 00, B for code 01 and A|B|C for code 10. For code 11 it is A|B when S5=1 and B when S5=0.
- R4: The second feedback (bus_o[5]) is register 2's output for codes 00, 01 and 10. For code 11 it is register 2's input C, in both modes.
- R5: S3=1 drives the pin value true, and S3=0 drives it inverted.
- R6: S4 (register 1) and S5 (register 2) select D type (0) or T type (1). A T register inverts its state at a clock enable when its input is 1, and holds it otherwise.
- R7: The effective clock of register 1 is clock1, ANDed with clkpin_i when S6=1. The same rule applies to register 2 with clock2 and S7. A register updates only on a low-to-high change of its effective clock.
- R8: While a register's clear term is 1, its visible output is 0 at once. The register stays 0 after the term falls, and no clock edge can set it during the clear.
- R9: preset_i sets a register to 1 at its next clock enable, overriding the D/T update. Without a clock enable it has no effect.
- R10: preload_i loads register 1 from preload_val_i[0] and register 2 from preload_val_i[1] at the next system edge, without any clock term. Preload overrides the clocked update, and the clear term overrides preload.
- R11: pin_oe_o equals the enable term. bus_o is {fb2, ~fb2, q1, ~q1, pinfb, ~pinfb} from bit 5 down to bit 0. pinfb is the driven pin value while enabled and pin_i otherwise.
- R12: System reset clears both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pt_i | input | 17 | Product term values from the AND array |
| cfg_i | input | 8 | Static configuration word, bit k = Sk |
| clkpin_i | input | 1 | Dedicated clock/input pin level |
| pin_i | input | 1 | External level seen on the I/O pin |
| preset_i | input | 1 | Shared synchronous preset |
| preload_i | input | 1 | Test preload strobe |
| preload_val_i | input | 2 | Preload values, bit 0 register 1, bit 1 register 2 |
| pin_o | output | 1 | Value driven to the pin |
| pin_oe_o | output | 1 | Pin drive enable |
| bus_o | output | 6 | Feedback pairs to the array |

## Verification
The bench builds the cell with its default of four product terms per group, which gives the 17-term layout above. With this size, the first and last term of each group can be driven singly to confirm the group boundaries. Every select code is stepped through in both the registered and combinational modes, so that each routing is reached. The priority ordering of clear, preload, preset and the clocked update is exercised directly by overlapping these stimuli.

// File: rtl/pld_cell_pkg.sv
`timescale 1ns/1ps
package pld_cell_pkg;
  localparam int unsigned CTRL_TERMS = 5;
  localparam int unsigned SUM_GROUPS = 3;
  localparam int unsigned BUS_W      = 6;

  // Field order matches cfg_i bit order S7..S0
  typedef struct packed {
    logic       ck2_pin;
    logic       ck1_pin;
    logic       t2;
    logic       t1;
    logic       act_high;
    logic       comb;
    logic [1:0] sel;
  } cell_cfg_t;

  typedef enum logic [1:0] {
    SEL_8   = 2'b00,
    SEL_4   = 2'b01,
    SEL_12  = 2'b10,
    SEL_ALT = 2'b11
  } sel_e;
endpackage

// File: rtl/cell_sum.sv
`timescale 1ns/1ps
module cell_sum #(
  parameter int unsigned TERMS  = 4,
  parameter int unsigned GROUPS = 3
) (
  input  logic [GROUPS*TERMS-1:0] terms_i,
  output logic [GROUPS-1:0]       sums_o
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign sums_o[g] = |terms_i[g*TERMS +: TERMS];
  end
endmodule

// File: rtl/cell_route.sv
`timescale 1ns/1ps
module cell_route
  import pld_cell_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       comb_i,
  input  logic       wide_i,
  input  logic [2:0] sums_i,
  input  logic       q2_i,
  output logic       d1_o,
  output logic       d2_o,
  output logic       comb_o,
  output logic       fb2_o
);
  logic sa, sb, sc;
  sel_e sel;

  always_comb begin
    sa     = sums_i[0];
    sb     = sums_i[1];
    sc     = sums_i[2];
    sel    = sel_e'(sel_i);
    d2_o   = sc;
    fb2_o  = (sel == SEL_ALT) ? sc : q2_i;
    comb_o = 1'b0;
    if (!comb_i) begin
      d1_o = (sel == SEL_12) ? (sa | sb | sc) : (sa | sb);
    end else begin
      d1_o = sa;
      unique case (sel)
        SEL_8:   comb_o = sa | sb;
        SEL_4:   comb_o = sb;
        SEL_12:  comb_o = sa | sb | sc;
        SEL_ALT: comb_o = wide_i ? (sa | sb) : sb;
        default: comb_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cell_reg.sv
`timescale 1ns/1ps
module cell_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ck_term_i,
  input  logic gate_pin_i,
  input  logic gate_en_i,
  input  logic clr_i,
  input  logic t_mode_i,
  input  logic din_i,
  input  logic preset_i,
  input  logic preload_i,
  input  logic preload_val_i,
  output logic q_o
);
  logic q, q_nx;
  logic ck_q, ck_eff, ck_rise;

  always_comb begin
    ck_eff  = ck_term_i & (gate_en_i ? gate_pin_i : 1'b1);
    ck_rise = ck_eff & ~ck_q;
    q_nx    = q;
    if (clr_i)          q_nx = 1'b0;
    else if (preload_i) q_nx = preload_val_i;
    else if (ck_rise)   q_nx = preset_i ? 1'b1 : (t_mode_i ? (q ^ din_i) : din_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= 1'b0;
      ck_q <= 1'b0;
    end else begin
      q    <= q_nx;
      ck_q <= ck_eff;
    end
  end

  assign q_o = q & ~clr_i;
endmodule

// File: rtl/pld_out_cell.sv
`timescale 1ns/1ps
module pld_out_cell
  import pld_cell_pkg::*;
#(
  parameter int unsigned P_TERMS = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [CTRL_TERMS+SUM_GROUPS*P_TERMS-1:0] pt_i,
  input  logic [7:0]                             cfg_i,
  input  logic                                   clkpin_i,
  input  logic                                   pin_i,
  input  logic                                   preset_i,
  input  logic                                   preload_i,
  input  logic [1:0]                             preload_val_i,
  output logic                                   pin_o,
  output logic                                   pin_oe_o,
  output logic [BUS_W-1:0]                       bus_o
);
  localparam int unsigned NPT = CTRL_TERMS + SUM_GROUPS * P_TERMS;

  cell_cfg_t             cfg;
  logic [1:0]            rst_sync;
  logic                  rst_n_sync;
  logic [SUM_GROUPS-1:0] sums;
  logic                  d1, d2, comb_val, fb2;
  logic [1:0]            q, clr_t, ck_t, gate_en, t_mode, din;
  logic                  out_raw, out_val, pin_fb;

  assign cfg = cell_cfg_t'(cfg_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_sync = rst_sync[1];

  cell_sum #(.TERMS(P_TERMS), .GROUPS(SUM_GROUPS)) u_sum (
    .terms_i (pt_i[NPT-1:CTRL_TERMS]),
    .sums_o  (sums)
  );

  cell_route u_route (
    .sel_i  (cfg.sel),
    .comb_i (cfg.comb),
    .wide_i (cfg.t2),
    .sums_i (sums),
    .q2_i   (q[1]),
    .d1_o   (d1),
    .d2_o   (d2),
    .comb_o (comb_val),
    .fb2_o  (fb2)
  );

  assign clr_t   = {pt_i[3], pt_i[0]};
  assign ck_t    = {pt_i[2], pt_i[1]};
  assign gate_en = {cfg.ck2_pin, cfg.ck1_pin};
  assign t_mode  = {cfg.t2, cfg.t1};
  assign din     = {d2, d1};

  for (genvar k = 0; k < 2; k++) begin : g_reg
    cell_reg u_reg (
      .clk           (clk),
      .rst_n         (rst_n_sync),
      .ck_term_i     (ck_t[k]),
      .gate_pin_i    (clkpin_i),
      .gate_en_i     (gate_en[k]),
      .clr_i         (clr_t[k]),
      .t_mode_i      (t_mode[k]),
      .din_i         (din[k]),
      .preset_i      (preset_i),
      .preload_i     (preload_i),
      .preload_val_i (preload_val_i[k]),
      .q_o           (q[k])
    );
  end

  always_comb begin
    out_raw = cfg.comb ? comb_val : q[0];
    out_val = cfg.act_high ? out_raw : ~out_raw;
    pin_fb  = pt_i[4] ? out_val : pin_i;
  end

  assign pin_o    = out_val;
  assign pin_oe_o = pt_i[4];
  assign bus_o    = {fb2, ~fb2, q[0], ~q[0], pin_fb, ~pin_fb};
endmodule

// File: rtl/cell_checker.sv
`timescale 1ns/1ps
module cell_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       clr1,
  input logic       cfg_comb,
  input logic       cfg_act_high,
  input logic       pin_i,
  input logic       preload,
  input logic       preload_v1,
  input logic       pin_o,
  input logic       pin_oe,
  input logic [5:0] bus
);
  // R8: clear term leaves register 1 at zero in the following cycle
  assert_clear_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr1 |=> !bus[3]);

  // R10: preload without clear loads register 1
  assert_preload_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (preload && !clr1) |=> (clr1 || (bus[3] == $past(preload_v1))));

  // R5: registered, active high: pin follows register 1
  assert_pol_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_comb && cfg_act_high) |-> (pin_o == bus[3]));

  // R5: registered, active low: pin follows register 1 inverted
  assert_pol_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_comb && !cfg_act_high) |-> (pin_o == bus[2]));

  // R11: undriven pin feeds back the external level
  assert_hiz_feedback_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> (bus[1] == pin_i));

  // R11: driven pin feeds back its own value
  assert_drive_feedback_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> (bus[1] == pin_o));
endmodule

bind pld_out_cell cell_checker u_cell_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .clr1         (pt_i[0]),
  .cfg_comb     (cfg_i[2]),
  .cfg_act_high (cfg_i[3]),
  .pin_i        (pin_i),
  .preload      (preload_i),
  .preload_v1   (preload_val_i[0]),
  .pin_o        (pin_o),
  .pin_oe       (pin_oe_o),
  .bus          (bus_o)
);

// File: tb/test_pld_out_cell.sv
`timescale 1ns/1ps
module test_pld_out_cell;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] pt;
  logic [7:0]  cfg;
  logic        clkpin, pin_i, preset, preload;
  logic [1:0]  pl_val;
  logic        pin_o, pin_oe;
  logic [5:0]  bus;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pld_out_cell i_pld_out_cell (
    .clk(clk), .rst_n(rst_n), .pt_i(pt), .cfg_i(cfg), .clkpin_i(clkpin),
    .pin_i(pin_i), .preset_i(preset), .preload_i(preload),
    .preload_val_i(pl_val), .pin_o(pin_o), .pin_oe_o(pin_oe), .bus_o(bus)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input logic got, input logic exp, input string tag);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic clk1(); pt[1] = 1'b1; step(); pt[1] = 1'b0; step(); endtask
  task automatic clk2(); pt[2] = 1'b1; step(); pt[2] = 1'b0; step(); endtask

  task automatic do_preload(input logic [1:0] v);
    pl_val = v; preload = 1'b1; step(); preload = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pt = '0; cfg = 8'h00; clkpin = 0; pin_i = 0;
    preset = 0; preload = 0; pl_val = 2'b00;
    repeat (3) step();
    check(bus[3], 1'b0, "R12 q1 in reset");
    rst_n = 1'b1;
    repeat (3) step();
    check(bus[3], 1'b0, "R12 q1 after reset");
    check(bus[5], 1'b0, "R12 q2 after reset");
    check(pin_o, 1'b1, "R12 active-low pin of cleared q1");
  endtask

  task automatic t_regroute();
    cfg = 8'h08; pt = '0; do_preload(2'b00);
    pt[6] = 1; clk1(); check(bus[3], 1'b1, "R2 group A into reg1");
    check(pin_o, 1'b1, "R2 pin follows q1");
    pt[6] = 0; pt[14] = 1; clk1(); check(bus[3], 1'b0, "R2 group C excluded code 00");
    cfg = 8'h0A; clk1(); check(bus[3], 1'b1, "R2 group C included code 10");
    cfg = 8'h09; clk1(); check(bus[3], 1'b0, "R2 code 01 same as 00");
    pt[14] = 0; pt[10] = 1; cfg = 8'h0B; clk1(); check(bus[3], 1'b1, "R2 group B code 11");
    pt[10] = 0; pt[12] = 1; clk1(); check(bus[3], 1'b1, "R1 top bit of group B");
    pt[12] = 0; pt[13] = 1; clk1(); check(bus[3], 1'b0, "R1 bottom bit of group C");
    pt[13] = 0; pt[8] = 1; clk1(); check(bus[3], 1'b1, "R1 top bit of group A");
    pt = '0;
  endtask

  task automatic t_comb();
    pt = '0;
    pt[7] = 1;
    cfg = 8'h0C; #1 check(pin_o, 1'b1, "R3 code 00 A");
    cfg = 8'h0D; #1 check(pin_o, 1'b0, "R3 code 01 A excluded");
    cfg = 8'h0E; #1 check(pin_o, 1'b1, "R3 code 10 A");
    cfg = 8'h2F; #1 check(pin_o, 1'b1, "R3 code 11 S5=1 A");
    cfg = 8'h0F; #1 check(pin_o, 1'b0, "R3 code 11 S5=0 A excluded");
    pt[7] = 0; pt[11] = 1;
    cfg = 8'h0D; #1 check(pin_o, 1'b1, "R3 code 01 B");
    cfg = 8'h0F; #1 check(pin_o, 1'b1, "R3 code 11 S5=0 B");
    pt[11] = 0; pt[16] = 1;
    cfg = 8'h0E; #1 check(pin_o, 1'b1, "R3 code 10 C");
    cfg = 8'h0C; #1 check(pin_o, 1'b0, "R3 code 00 C excluded");
    cfg = 8'h0D; #1 check(pin_o, 1'b0, "R3 code 01 C excluded");
    pt = '0; step();
  endtask

  task automatic t_fb();
    cfg = 8'h0B; pt = '0; do_preload(2'b00);
    pt[15] = 1; #1 check(bus[5], 1'b1, "R4 code 11 feeds C");
    check(bus[4], 1'b0, "R11 fb2 complement");
    pt[15] = 0; #1 check(bus[5], 1'b0, "R4 code 11 follows C low");
    pt[15] = 1; clk2(); pt[15] = 0;
    cfg = 8'h08; #1 check(bus[5], 1'b1, "R4 code 00 feeds q2");
    cfg = 8'h0B; #1 check(bus[5], 1'b0, "R4 code 11 not q2");
    cfg = 8'h0A; #1 check(bus[5], 1'b1, "R4 code 10 feeds q2");
    cfg = 8'h0F; #1 check(bus[5], 1'b0, "R4 comb code 11 not q2");
    step();
  endtask

  task automatic t_pol();
    pt = '0; cfg = 8'h00; do_preload(2'b01);
    #1 check(pin_o, 1'b0, "R5 registered active low");
    cfg = 8'h08; #1 check(pin_o, 1'b1, "R5 registered active high");
    cfg = 8'h04; #1 check(pin_o, 1'b1, "R5 comb active low of 0");
    cfg = 8'h0C; #1 check(pin_o, 1'b0, "R5 comb active high of 0");
    step();
  endtask

  task automatic t_toggle();
    cfg = 8'h18; pt = '0; do_preload(2'b00);
    pt[5] = 1; clk1(); check(bus[3], 1'b1, "R6 T1 toggles up");
    clk1(); check(bus[3], 1'b0, "R6 T1 toggles down");
    pt[5] = 0; clk1(); check(bus[3], 1'b0, "R6 T1 holds on 0");
    cfg = 8'h28; do_preload(2'b00);
    pt[13] = 1; clk2(); check(bus[5], 1'b1, "R6 T2 toggles up");
    clk2(); check(bus[5], 1'b0, "R6 T2 toggles down");
    pt[13] = 0; clk2(); check(bus[5], 1'b0, "R6 T2 holds on 0");
  endtask

  task automatic t_gate();
    cfg = 8'h48; pt = '0; clkpin = 0; do_preload(2'b00);
    pt[5] = 1; clk1(); check(bus[3], 1'b0, "R7 S6 gate closed");
    clkpin = 1; clk1(); check(bus[3], 1'b1, "R7 S6 gate open");
    clkpin = 0; do_preload(2'b00);
    pt[1] = 1; step(); check(bus[3], 1'b0, "R7 term high pin low");
    clkpin = 1; step(); check(bus[3], 1'b1, "R7 pin rise with term high");
    clkpin = 0; pt[1] = 0; step();
    cfg = 8'h08; do_preload(2'b00);
    clk1(); check(bus[3], 1'b1, "R7 S6=0 ignores pin");
    pt[5] = 0;
    cfg = 8'h88; do_preload(2'b00);
    pt[13] = 1; clk2(); check(bus[5], 1'b0, "R7 S7 gate closed");
    clkpin = 1; clk2(); check(bus[5], 1'b1, "R7 S7 gate open");
    clkpin = 0; pt = '0; step();
  endtask

  task automatic t_clear();
    cfg = 8'h08; pt = '0; do_preload(2'b11);
    check(bus[3], 1'b1, "R8 q1 preloaded");
    pt[0] = 1; #1 check(bus[3], 1'b0, "R8 clear visible at once");
    step(); pt[0] = 0; #1 check(bus[3], 1'b0, "R8 stays cleared");
    pt[0] = 1; pt[5] = 1; clk1(); pt[0] = 0; pt[5] = 0; step();
    check(bus[3], 1'b0, "R8 clock blocked during clear");
    do_preload(2'b11);
    pt[3] = 1; #1 check(bus[5], 1'b0, "R8 clear2 visible at once");
    check(bus[3], 1'b1, "R8 clear2 leaves q1");
    step(); pt[3] = 0; step();
    check(bus[5], 1'b0, "R8 q2 stays cleared");
  endtask

  task automatic t_preset();
    cfg = 8'h08; pt = '0; do_preload(2'b00);
    preset = 1; clk1(); check(bus[3], 1'b1, "R9 preset over D");
    do_preload(2'b00); step(); step();
    check(bus[3], 1'b0, "R9 preset needs clock edge");
    cfg = 8'h18; do_preload(2'b01);
    pt[5] = 1; clk1(); check(bus[3], 1'b1, "R9 preset over toggle");
    preset = 0; pt = '0;
  endtask

  task automatic t_preload();
    cfg = 8'h08; pt = '0;
    do_preload(2'b10);
    check(bus[3], 1'b0, "R10 q1 loaded 0");
    check(bus[5], 1'b1, "R10 q2 loaded 1");
    do_preload(2'b01);
    check(bus[3], 1'b1, "R10 q1 loaded 1");
    check(bus[5], 1'b0, "R10 q2 loaded 0");
    pt[0] = 1; do_preload(2'b01); pt[0] = 0; #1
    check(bus[3], 1'b0, "R10 clear beats preload");
    do_preload(2'b01);
    pt[5] = 1; pt[1] = 1; pl_val = 2'b00; preload = 1; step();
    preload = 0; pt[1] = 0; step();
    check(bus[3], 1'b0, "R10 preload beats clock");
    pt = '0;
  endtask

  task automatic t_oe();
    cfg = 8'h08; pt = '0; do_preload(2'b01);
    pin_i = 0; #1
    check(pin_oe, 1'b0, "R11 enable low");
    check(bus[1], 1'b0, "R11 pin feedback external 0");
    check(bus[0], 1'b1, "R11 pin feedback complement");
    pin_i = 1; #1 check(bus[1], 1'b1, "R11 pin feedback external 1");
    pt[4] = 1; pin_i = 0; #1
    check(pin_oe, 1'b1, "R11 enable high");
    check(bus[1], 1'b1, "R11 pin feedback driven value");
    check(bus[2], 1'b0, "R11 q1 complement");
    pt = '0; step();
  endtask

  initial begin
    t_reset();
    t_regroute();
    t_comb();
    t_fb();
    t_pol();
    t_toggle();
    t_gate();
    t_clear();
    t_preset();
    t_preload();
    t_oe();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule